// File: doc/BRIEF.md
# Interrupt Controller Read and Poll Unit

This block sits on the read side of a two-address interrupt controller. It keeps the most recent read-control command word. That word selects polling, chooses which register a read returns and turns special mask mode on or off. The block also drives the read data bus. A read at the even address returns one of three things: a poll word, the pending-request register or the in-service register, as the held command bits select. A read at the odd address always returns the mask register.

The special-mask-mode flag goes to the controller's arbiter. In this mode the arbiter services unmasked requests in arrival order and ignores priority. A poll read stands in for an interrupt acknowledge. The block takes the winning level from an external priority resolver and raises a one-cycle acknowledge that tells the in-service logic to set that level's bit.

Reads use a synchronous strobe. The data for a read strobed in cycle t is on `rd_data` from cycle t+1 and stays there until the next read. Command word bit positions: bit 6 enables a special-mask update (ESM), bit 5 is the special-mask value (SMV), bit 2 is poll (PL), bit 1 enables register read (RDE) and bit 0 selects the in-service register (SIS). The other bits are ignored.

Top module: `rdpoll_unit`

## Requirements
- R1: A command write with bit 6 = 1 and bit 5 = 1 sets `special_mask` from the next cycle.
- R2: A command write with bit 6 = 1 and bit 5 = 0 clears `special_mask` from the next cycle.
- R3: A command write with bit 6 = 0 leaves `special_mask` unchanged.
- R4: An even-address read with poll armed (bit 2 of the last command) and `win_valid` = 1 pulses `poll_ack` for one cycle in the next cycle, with `poll_level` equal to the `win_level` seen at the read.
- R5: The poll word has bit 7 = 1, the winning level in bits 2..0 and 0 in every other bit.
- R6: A poll read with `win_valid` = 0 returns 0 and does not raise `poll_ack`.
- R7: An even-address read with poll not armed and bit 1 = 1 returns `irr` if bit 0 = 0 and `isr` if bit 0 = 1. With bit 1 = 0 it returns 0.
- R8: An odd-address read returns `imr` and has no side effect on the poll state.
- R9: The register-read selection is held across any number of reads until the next command write.
- R10: One even-address read consumes the poll. Later even reads follow R7 until a new command arms the poll again. A command write in the same cycle as the read takes precedence.
- R11: After reset `rd_data`, `poll_ack` and `special_mask` are 0 and no selection is active. `rd_data` changes only in the cycle after a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Read-control command write strobe |
| cmd_data | input | 8 | Command word |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 1 | Read address, 0 even, 1 odd |
| irr | input | 8 | Pending-request register |
| isr | input | 8 | In-service register |
| imr | input | 8 | Mask register |
| win_valid | input | 1 | Resolver has an unmasked winner |
| win_level | input | 3 | Resolver's winning level |
| rd_data | output | 8 | Read data, registered |
| special_mask | output | 1 | Special mask mode to arbiter |
| poll_ack | output | 1 | Poll acknowledge pulse |
| poll_level | output | 3 | Level to mark in service |

## Verification
The assertions check the following on every cycle: the special-mask update rules, the mask register returned by odd reads, that `rd_data` holds between reads, and that an acknowledge only ever follows an even read that had a valid winner. Some behaviour depends on command history and cannot be seen one cycle at a time: a held selection surviving many reads, a poll being consumed exactly once, the poll word layout, and a write racing a read in the same cycle. Only the bench scenarios show these, checked against its own model of the command state.

// File: rtl/rdpoll_pkg.sv
package rdpoll_pkg;
  localparam int unsigned CW_SIS = 0;
  localparam int unsigned CW_RDE = 1;
  localparam int unsigned CW_PL  = 2;
  localparam int unsigned CW_SMV = 5;
  localparam int unsigned CW_ESM = 6;

  typedef struct packed {
    logic poll;
    logic rd_reg;
    logic rd_isr;
    logic smm;
  } ctl_t;
endpackage

// File: rtl/rdpoll_ctl.sv
module rdpoll_ctl
  import rdpoll_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_data,
  input  logic       poll_take,
  output ctl_t       ctl_q
);
  ctl_t ctl_d;
  logic unused_bits;

  assign unused_bits = ^{cmd_data[7], cmd_data[4:3]};

  always_comb begin
    ctl_d = ctl_q;
    if (cmd_wr) begin
      ctl_d.poll   = cmd_data[CW_PL];
      ctl_d.rd_reg = cmd_data[CW_RDE];
      ctl_d.rd_isr = cmd_data[CW_SIS];
      if (cmd_data[CW_ESM]) ctl_d.smm = cmd_data[CW_SMV];
    end else if (poll_take) begin
      ctl_d.poll = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end
endmodule

// File: rtl/rdpoll_mux.sv
module rdpoll_mux
  import rdpoll_pkg::*;
#(
  parameter int unsigned N_LVL = 8,
  parameter int unsigned DW    = 8,
  localparam int unsigned LW   = $clog2(N_LVL)
) (
  input  ctl_t          ctl,
  input  logic          rd_addr,
  input  logic [N_LVL-1:0] irr,
  input  logic [N_LVL-1:0] isr,
  input  logic [N_LVL-1:0] imr,
  input  logic          win_valid,
  input  logic [LW-1:0] win_level,
  output logic [DW-1:0] rd_word,
  output logic          ack_req
);
  logic [DW-1:0] poll_word;

  always_comb begin
    poll_word = '0;
    if (win_valid) begin
      poll_word[DW-1]   = 1'b1;
      poll_word[LW-1:0] = win_level;
    end
  end

  always_comb begin
    rd_word = '0;
    ack_req = 1'b0;
    if (rd_addr) begin
      rd_word = DW'(imr);
    end else if (ctl.poll) begin
      rd_word = poll_word;
      ack_req = win_valid;
    end else if (ctl.rd_reg) begin
      rd_word = ctl.rd_isr ? DW'(isr) : DW'(irr);
    end
  end
endmodule

// File: rtl/rdpoll_unit.sv
module rdpoll_unit
  import rdpoll_pkg::*;
#(
  parameter int unsigned N_LVL = 8,
  parameter int unsigned DW    = 8,
  localparam int unsigned LW   = $clog2(N_LVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [7:0]       cmd_data,
  input  logic             rd_en,
  input  logic             rd_addr,
  input  logic [N_LVL-1:0] irr,
  input  logic [N_LVL-1:0] isr,
  input  logic [N_LVL-1:0] imr,
  input  logic             win_valid,
  input  logic [LW-1:0]    win_level,
  output logic [DW-1:0]    rd_data,
  output logic             special_mask,
  output logic             poll_ack,
  output logic [LW-1:0]    poll_level
);
  ctl_t          ctl_q;
  logic [DW-1:0] rd_word;
  logic          ack_req;
  logic          even_rd;
  logic [DW-1:0] rd_data_d;
  logic          poll_ack_d;
  logic [LW-1:0] poll_level_d;

  assign even_rd = rd_en && !rd_addr;

  rdpoll_ctl i_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .poll_take(even_rd), .ctl_q(ctl_q)
  );

  rdpoll_mux #(.N_LVL(N_LVL), .DW(DW)) i_mux (
    .ctl(ctl_q), .rd_addr(rd_addr), .irr(irr), .isr(isr), .imr(imr),
    .win_valid(win_valid), .win_level(win_level),
    .rd_word(rd_word), .ack_req(ack_req)
  );

  always_comb begin
    rd_data_d    = rd_data;
    poll_ack_d   = 1'b0;
    poll_level_d = poll_level;
    if (rd_en) begin
      rd_data_d = rd_word;
      if (ack_req && !rd_addr) begin
        poll_ack_d   = 1'b1;
        poll_level_d = win_level;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data    <= '0;
      poll_ack   <= 1'b0;
      poll_level <= '0;
    end else begin
      rd_data    <= rd_data_d;
      poll_ack   <= poll_ack_d;
      poll_level <= poll_level_d;
    end
  end

  assign special_mask = ctl_q.smm;
endmodule

// File: rtl/rdpoll_chk.sv
module rdpoll_chk #(
  parameter int unsigned N_LVL = 8,
  parameter int unsigned DW    = 8,
  localparam int unsigned LW   = $clog2(N_LVL)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_wr,
  input logic [7:0]       cmd_data,
  input logic             rd_en,
  input logic             rd_addr,
  input logic [N_LVL-1:0] imr,
  input logic             win_valid,
  input logic [DW-1:0]    rd_data,
  input logic             special_mask,
  input logic             poll_ack
);
  AST_SMM_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && cmd_data[6] && cmd_data[5] |=> special_mask); // R1
  AST_SMM_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && cmd_data[6] && !cmd_data[5] |=> !special_mask); // R2
  AST_SMM_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !cmd_data[6] |=> $stable(special_mask)); // R3
  AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    poll_ack |-> $past(rd_en && !rd_addr && win_valid)); // R4
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    poll_ack |=> !poll_ack || $past(rd_en)); // R4
  AST_ODD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_addr |=> rd_data == DW'($past(imr))); // R8
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R11
endmodule

bind rdpoll_unit rdpoll_chk #(.N_LVL(N_LVL), .DW(DW)) i_rdpoll_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .imr(imr), .win_valid(win_valid),
  .rd_data(rd_data), .special_mask(special_mask), .poll_ack(poll_ack)
);

// File: tb/test_rdpoll_unit.sv
module test_rdpoll_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_wr;
  logic [7:0] cmd_data;
  logic       rd_en, rd_addr;
  logic [7:0] irr, isr, imr;
  logic       win_valid;
  logic [2:0] win_level;
  logic [7:0] rd_data;
  logic       special_mask, poll_ack;
  logic [2:0] poll_level;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of command state
  bit m_poll, m_rde, m_sis, m_smm;
  logic [7:0] e_rd;
  bit e_ack;
  logic [2:0] e_lvl;
  string e_tag;

  always #2 clk = ~clk;

  rdpoll_unit i_rdpoll_unit (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .irr(irr), .isr(isr), .imr(imr),
    .win_valid(win_valid), .win_level(win_level), .rd_data(rd_data),
    .special_mask(special_mask), .poll_ack(poll_ack), .poll_level(poll_level)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] poll_byte(bit v, logic [2:0] l);
    return v ? {1'b1, 4'b0, l} : 8'h00;
  endfunction

  // one cycle: inputs set at negedge, model advanced, outputs checked at next negedge
  task automatic cyc();
    e_ack = 0;
    if (rd_en) begin
      if (rd_addr) begin e_rd = imr; e_tag = "R8"; end
      else if (m_poll) begin
        e_rd = poll_byte(win_valid, win_level);
        e_ack = win_valid; e_lvl = win_level;
        e_tag = win_valid ? "R5" : "R6";
      end else if (m_rde) begin
        e_rd = m_sis ? isr : irr; e_tag = "R7";
      end else begin e_rd = 8'h00; e_tag = "R7"; end
    end else e_tag = "R11";
    if (cmd_wr) begin
      m_poll = cmd_data[2]; m_rde = cmd_data[1]; m_sis = cmd_data[0];
      if (cmd_data[6]) m_smm = cmd_data[5];
    end else if (rd_en && !rd_addr) m_poll = 0;
    @(negedge clk);
    check(e_tag, rd_data, e_rd);
    check("R4 ack", poll_ack, e_ack);
    if (e_ack) check("R4 level", poll_level, e_lvl);
    check("R1 R2 R3 smm", special_mask, m_smm);
    cmd_wr = 0; rd_en = 0;
  endtask

  task automatic wr(logic [7:0] d);
    cmd_wr = 1; cmd_data = d; cyc();
  endtask

  task automatic rd(bit a);
    rd_en = 1; rd_addr = a; cyc();
  endtask

  initial begin
    void'($urandom(32'h1bad5eed));
    rst_n = 0; cmd_wr = 0; cmd_data = 0; rd_en = 0; rd_addr = 0;
    irr = 8'h12; isr = 8'h40; imr = 8'h81; win_valid = 0; win_level = 0;
    e_rd = 0; e_lvl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R11 reset data", rd_data, 0);
    check("R11 reset ack", poll_ack, 0);
    check("R11 reset smm", special_mask, 0);
    rd(0); // R11: no selection reads 0
    wr(8'h60); // R1
    wr(8'h00); // R3 keep
    wr(8'h02); rd(0); rd(0); rd(1); rd(0); // R7 irr, R9 held, R8
    wr(8'h03); rd(0); // R7 isr
    win_valid = 1; win_level = 3'd5;
    wr(8'h04); rd(1); rd(0); rd(0); // R8 keeps poll, R4 R5, R10 consumed
    win_valid = 0; wr(8'h06); rd(0); rd(0); // R6 then R10 falls back to irr
    win_valid = 1; win_level = 3'd1; wr(8'h04);
    rd_en = 1; rd_addr = 0; cmd_wr = 1; cmd_data = 8'h04; cyc(); // R10 write wins
    rd(0);
    wr(8'h40); // R2
    for (int i = 0; i < 3000; i++) begin
      cmd_wr = ($urandom % 5) == 0; cmd_data = $urandom;
      rd_en = $urandom % 2; rd_addr = $urandom % 2;
      irr = $urandom; isr = $urandom; imr = $urandom;
      win_valid = ($urandom % 4) != 0; win_level = $urandom;
      cyc();
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk);
        errors++; checks++; $display("FAIL watchdog: actual timeout expected done"); end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule